// File: doc/BRIEF.md
# DMA Burst Halt-Timing Sequencer

This block works out how long the processor must be held off while a general-purpose DMA burst runs, and it produces the timing for the burst. A start strobe marks the write that launches the burst. The processor is then allowed one more bus cycle. After that the halt goes high. While the halt is high, the block passes through four phases in order:

1. A wait that lines up with an 8-cycle grid counted from reset.
2. A fixed overhead slot.
3. For each enabled channel, a channel slot followed by one slot per byte.
4. A closing wait that makes the whole halt a whole number of processor clocks long.

The block emits one strobe per byte, tagged with the active channel. It gives a one-cycle done pulse when the halt is released. The length of the halt depends on the phase at which the halt begins, as well as on the byte counts. The block does not move any data; a separate datapath consumes the strobes.

The sequencer is a single state machine with seven states:

- `S_IDLE` waits for start.
- `S_GRACE` covers the extra bus cycle.
- `S_ALIGN` waits for the 8-cycle grid.
- `S_HEAD` is the overall overhead slot.
- `S_CHAN` is one channel's overhead slot.
- `S_XFER` holds the byte slots.
- `S_TAIL` is the closing processor-clock alignment.

The transitions are:

- **idle-to-grace** on start.
- **grace-to-align** after one processor clock.
- **align-to-head** when the reset-referenced phase reaches a multiple of 8.
- **head-to-chan**, or **head-to-tail** when no channel is enabled.
- **chan-to-xfer** after 8 cycles.
- **xfer-to-chan** for the next enabled channel, or **xfer-to-tail** after the last byte of the last channel.
- **tail-to-idle** when the halt length is a multiple of the processor clock.

Top module: `dma_align_ctl`

## Requirements
- R1: After reset, `halt`, `xfer_stb` and `done` are low.
- R2: If `start` is high in cycle c while idle, the processor clock period P (`cpu_period`, sampled in cycle c) is granted as one extra bus cycle. `halt` is first high in cycle c+P+1.
- R3: Let n be the number of clock edges since reset release, counted in the first halted cycle. The alignment wait lasts 8 - (n mod 8) cycles, so it is 1 to 8 cycles and never zero.
- R4: After the alignment wait, the burst lasts 8 cycles, plus 8 per enabled channel, plus 8 per byte moved.
- R5: After the burst, a closing wait of 1 to P cycles makes the total halt length a whole multiple of P. Supported values of P are 6, 8 and 12.
- R6: The burst opens with the 8-cycle overhead slot. Enabled channels are then served in ascending index order. Each channel gets an 8-cycle slot, then one 8-cycle slot per byte. `xfer_stb` is high on the first cycle of each byte slot, with `xfer_ch` giving the channel index. Channel i's count occupies bits [i*CNT_W +: CNT_W] of `byte_cnt`, and bit i of `chan_en` enables it.
- R7: A byte count of 0 on an enabled channel moves 2^CNT_W bytes. Counts of disabled channels have no effect.
- R8: `done` is high for exactly one cycle: the first cycle in which `halt` is low after a burst.
- R9: A `start` that arrives during the grace cycle or during the halt is ignored. It does not change the running burst and does not begin another one.
- R10: `chan_en`, `byte_cnt` and `cpu_period` are captured with the accepted start. Later changes to them do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, one tick per master cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst launch strobe |
| chan_en | input | NCH | Per-channel enable mask |
| byte_cnt | input | NCH*CNT_W | Per-channel byte counts, 0 meaning 2^CNT_W |
| cpu_period | input | PER_W | Processor clock period in master cycles |
| halt | output | 1 | Processor hold-off |
| xfer_stb | output | 1 | One pulse per byte moved |
| xfer_ch | output | CH_W | Channel index of the current byte |
| done | output | 1 | One-cycle release pulse |

## Verification
The hardest case to reach from the ports is a chosen phase of the reset-referenced 8-cycle grid at the moment the halt begins. The bench reaches it by counting edges since reset release and launching start only when that count modulo 8 hits a chosen value. This reproduces a known 2-cycle alignment wait, which gives a 48-cycle halt for three bytes at a 6-cycle processor clock. Start strobes that land inside the grace cycle or deep inside the halt are produced by pulsing start again a fixed number of cycles after launch, together with different inputs. The expected halt length and strobe pattern must then stay those of the first launch. A zero byte count is exercised with a narrow count width, so that the wrap to the full range finishes quickly.

// File: rtl/dma_align_pkg.sv
package dma_align_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_GRACE,
        S_ALIGN,
        S_HEAD,
        S_CHAN,
        S_XFER,
        S_TAIL
    } dma_state_e;
endpackage

// File: rtl/dma_phase8.sv
// Free-running position within the 8-cycle grid referenced to reset release.
module dma_phase8 (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] ph
);
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 3'd0;
        else        ph <= ph + 3'd1;
    end
endmodule

// File: rtl/dma_period_ctr.sv
// Counts master cycles modulo the processor clock period.
module dma_period_ctr #(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PER_W-1:0] period,
    output logic             last
);
    logic [PER_W-1:0] val;

    assign last = (val == period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)    val <= '0;
        else if (clr)  val <= '0;
        else if (last) val <= '0;
        else           val <= val + PER_W'(1);
    end
endmodule

// File: rtl/dma_chan_pick.sv
// Lowest enabled channel whose index is at or above a starting point.
module dma_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W:0]   from,
    output logic            found,
    output logic [CH_W-1:0] idx
);
    localparam int FW = CH_W + 1;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (FW'(i) >= from)) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_align_ctl.sv
module dma_align_ctl
    import dma_align_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 16,
    parameter int PER_W = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NCH-1:0]       chan_en,
    input  logic [NCH*CNT_W-1:0] byte_cnt,
    input  logic [PER_W-1:0]     cpu_period,
    output logic                 halt,
    output logic                 xfer_stb,
    output logic [CH_W-1:0]      xfer_ch,
    output logic                 done
);
    dma_state_e       state, nxt;
    logic [2:0]       sub;
    logic [2:0]       ph;
    logic [CH_W-1:0]  ch_q;
    logic [CNT_W-1:0] rem;
    logic [NCH-1:0]   en_q;
    logic [CNT_W-1:0] cnt_q [NCH];
    logic [PER_W-1:0] p_q;
    logic             done_q;
    logic             per_last, per_clr;
    logic [CH_W:0]    pick_from;
    logic             pick_found;
    logic [CH_W-1:0]  pick_idx;
    logic             slot_end, last_byte;

    assign slot_end  = (sub == 3'd7);
    assign last_byte = (rem == CNT_W'(1));
    assign per_clr   = (state == S_IDLE) || (state == S_GRACE && per_last);
    assign pick_from = (state == S_HEAD) ? '0 : ({1'b0, ch_q} + (CH_W+1)'(1));

    dma_phase8 u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph)
    );

    dma_period_ctr #(.PER_W(PER_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (per_clr),
        .period (p_q),
        .last   (per_last)
    );

    dma_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask  (en_q),
        .from  (pick_from),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start)    nxt = S_GRACE;                    // idle-to-grace
            S_GRACE: if (per_last) nxt = S_ALIGN;                    // grace-to-align
            S_ALIGN: if (ph == 3'd7) nxt = S_HEAD;                   // align-to-head
            S_HEAD:  if (slot_end) nxt = pick_found ? S_CHAN : S_TAIL;
            S_CHAN:  if (slot_end) nxt = S_XFER;                     // chan-to-xfer
            S_XFER:  if (slot_end && last_byte)
                         nxt = pick_found ? S_CHAN : S_TAIL;
            S_TAIL:  if (per_last) nxt = S_IDLE;                     // tail-to-idle
            default: nxt = S_IDLE;
        endcase
    end

    // captured request, slot counter, channel walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            p_q    <= '0;
            sub    <= '0;
            ch_q   <= '0;
            rem    <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < NCH; i++) cnt_q[i] <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                en_q <= chan_en;
                p_q  <= cpu_period;
                for (int i = 0; i < NCH; i++) cnt_q[i] <= byte_cnt[i*CNT_W +: CNT_W];
            end
            if (state == S_HEAD || state == S_CHAN || state == S_XFER) sub <= sub + 3'd1;
            else                                                       sub <= 3'd0;
            if (pick_found && slot_end &&
                (state == S_HEAD || (state == S_XFER && last_byte))) begin
                ch_q <= pick_idx;
                rem  <= cnt_q[pick_idx];
            end else if (state == S_XFER && slot_end) begin
                rem <= rem - CNT_W'(1);
            end
            done_q <= (state == S_TAIL) && per_last;
        end
    end

    // outputs
    always_comb begin
        halt     = (state == S_ALIGN) || (state == S_HEAD) || (state == S_CHAN) ||
                   (state == S_XFER)  || (state == S_TAIL);
        xfer_stb = (state == S_XFER) && (sub == 3'd0);
        xfer_ch  = ch_q;
        done     = done_q;
    end
endmodule

// File: rtl/dma_align_chk.sv
module dma_align_chk
    import dma_align_pkg::*;
#(
    parameter int PER_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             done,
    input logic             xfer_stb,
    input dma_state_e       state,
    input logic [2:0]       ph,
    input logic [PER_W-1:0] p_q
);
    logic [23:0] hcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    hcnt <= '0;
        else if (halt) hcnt <= hcnt + 24'd1;
        else           hcnt <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                           // R8
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!halt && $past(halt)));                                          // R8
    AST_HEAD_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HEAD && $past(state) == S_ALIGN) |-> (ph == 3'd0));            // R3
    AST_HALT_WHOLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt) |-> ((hcnt % 24'(p_q)) == 24'd0));                             // R5
    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |=> !xfer_stb);                                                   // R6
endmodule

bind dma_align_ctl dma_align_chk #(.PER_W(PER_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .done     (done),
    .xfer_stb (xfer_stb),
    .state    (state),
    .ph       (ph),
    .p_q      (p_q)
);

// File: tb/dma_align_ctl_bench.sv
module dma_align_ctl_bench;
    localparam int NCH = 4;
    localparam int CNT_W = 8;
    localparam int PER_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [NCH-1:0]     chan_en = '0;
    logic [NCH*CNT_W-1:0] byte_cnt = '0;
    logic [PER_W-1:0]   cpu_period = 4'd6;
    logic               halt, xfer_stb, done;
    logic [1:0]         xfer_ch;

    dma_align_ctl #(.NCH(NCH), .CNT_W(CNT_W), .PER_W(PER_W)) u_dma_align_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
        .byte_cnt(byte_cnt), .cpu_period(cpu_period), .halt(halt),
        .xfer_stb(xfer_stb), .xfer_ch(xfer_ch), .done(done)
    );

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // edges since reset release (the count named in R3)
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor
    int hs, hlen, nrise, nstb, fst, ndone, dcyc, lastch;
    int chcnt [NCH];
    bit order_bad, halt_d;

    task automatic clear_mon();
        hs = -1; hlen = 0; nrise = 0; nstb = 0; fst = -1; ndone = 0; dcyc = -1;
        lastch = 0; order_bad = 1'b0;
        for (int i = 0; i < NCH; i++) chcnt[i] = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (halt && !halt_d) begin hs = cyc; nrise++; end
            if (halt) hlen++;
            if (xfer_stb) begin
                if (nstb == 0) fst = cyc;
                if (int'(xfer_ch) < lastch) order_bad = 1'b1;
                lastch = int'(xfer_ch);
                chcnt[xfer_ch]++;
                nstb++;
            end
            if (done) begin ndone++; dcyc = cyc; end
        end
        halt_d = halt;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_cnt(logic [NCH-1:0] m, logic [NCH*CNT_W-1:0] c, int i);
        int v;
        if (!m[i]) return 0;
        v = int'(c[i*CNT_W +: CNT_W]);
        return (v == 0) ? (1 << CNT_W) : v;
    endfunction

    // Launch one burst and check it against R2..R10.
    task automatic run(logic [NCH-1:0] m, logic [NCH*CNT_W-1:0] c, int p,
                       int pre, int align, int bump, int exp_bytes);
        int cstart, h, w1, nch, bytes, b, r, w2, t, k;
        clear_mon();
        for (int i = 0; i < pre; i++) begin @(posedge clk); #1; end
        if (align >= 0) begin
            @(posedge clk); #1;
            while ((cyc % 8) != align) begin @(posedge clk); #1; end
        end else begin
            @(posedge clk); #1;
        end
        chan_en = m; byte_cnt = c; cpu_period = PER_W'(p); start = 1'b1;
        cstart = cyc;
        @(posedge clk); #1;
        start = 1'b0;
        k = 1;
        while (ndone == 0 && k < 8000) begin
            if (bump > 0 && k == bump) begin
                start = 1'b1; chan_en = ~m; cpu_period = 4'd12;
                byte_cnt = {NCH{8'd9}};
            end
            if (bump > 0 && k == bump + 1) start = 1'b0;
            @(posedge clk); #1;
            k++;
        end
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin @(posedge clk); #1; end

        h = cstart + p + 1;
        w1 = 8 - (h % 8);
        nch = 0; bytes = 0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) nch++;
            bytes += eff_cnt(m, c, i);
        end
        b = 8 + 8 * nch + 8 * bytes;
        r = (w1 + b) % p;
        w2 = (r == 0) ? p : p - r;
        t = w1 + b + w2;

        check(hs == h, "R2", "halt start cycle", hs, h);
        check(hlen == t, "R3/R4/R5", "halt length", hlen, t);
        check((hlen % p) == 0, "R5", "halt length modulo period", hlen % p, 0);
        check(nstb == exp_bytes, "R6", "strobe count", nstb, exp_bytes);
        check(!order_bad, "R6", "ascending channel order", int'(order_bad), 0);
        begin
            int bad = 0;
            for (int i = 0; i < NCH; i++) if (chcnt[i] != eff_cnt(m, c, i)) bad++;
            check(bad == 0, "R6", "channels with wrong byte count", bad, 0);
        end
        if (nstb > 0) check(fst == h + w1 + 16, "R6", "first strobe cycle", fst, h + w1 + 16);
        check(ndone == 1, "R8", "done pulses", ndone, 1);
        check(dcyc == h + t, "R8", "done cycle", dcyc, h + t);
        if (bump > 0) check(nrise == 1, "R9", "halt episodes", nrise, 1);
    endtask

    // {mask, cnt3, cnt2, cnt1, cnt0, period, predelay, expected bytes}
    localparam int VW = 4 + 32 + 4 + 4 + 12;
    localparam logic [VW-1:0] VEC [8] = '{
        {4'b0001, 8'd0, 8'd0, 8'd0, 8'd3, 4'd6,  4'd0, 12'd3},
        {4'b0101, 8'd0, 8'd1, 8'd0, 8'd2, 4'd8,  4'd1, 12'd3},
        {4'b1111, 8'd1, 8'd1, 8'd1, 8'd1, 4'd12, 4'd2, 12'd4},
        {4'b0000, 8'd5, 8'd5, 8'd5, 8'd5, 4'd6,  4'd3, 12'd0},
        {4'b1010, 8'd2, 8'd0, 8'd4, 8'd0, 4'd12, 4'd4, 12'd6},
        {4'b1000, 8'd5, 8'd0, 8'd0, 8'd0, 4'd8,  4'd5, 12'd5},
        {4'b0110, 8'd0, 8'd3, 8'd1, 8'd0, 4'd6,  4'd6, 12'd4},
        {4'b0011, 8'd0, 8'd0, 8'd7, 8'd2, 4'd12, 4'd7, 12'd9}
    };

    initial begin
        clear_mon();
        halt_d = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state, with reset still applied
        check(halt == 1'b0, "R1", "halt in reset", int'(halt), 0);
        check(xfer_stb == 1'b0, "R1", "xfer_stb in reset", int'(xfer_stb), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(halt == 1'b0 && done == 1'b0, "R1", "idle after reset", int'(halt | done), 0);

        for (int v = 0; v < 8; v++) begin
            run(VEC[v][55:52], VEC[v][51:20], int'(VEC[v][19:16]),
                int'(VEC[v][15:12]), -1, 0, int'(VEC[v][11:0]));
        end

        // R3: two-cycle grid wait, one channel, three bytes, 6-cycle clock -> 48
        run(4'b0001, {8'd0, 8'd0, 8'd0, 8'd3}, 6, 0, 7, 0, 3);
        check(hlen == 48, "R3", "known 48-cycle halt", hlen, 48);
        // R3: halt begins on the grid -> full 8-cycle wait
        run(4'b0001, {8'd0, 8'd0, 8'd0, 8'd1}, 8, 0, 7, 0, 1);
        check(hlen == 8 + 24 + 8, "R3", "aligned start waits eight", hlen, 40);
        // R5: 12-cycle clock at several grid phases
        for (int a = 0; a < 8; a += 3) run(4'b0100, {8'd0, 8'd2, 8'd0, 8'd0}, 12, 0, a, 0, 2);
        // R7: zero count on an enabled channel moves 2^CNT_W bytes
        run(4'b0010, {8'd0, 8'd0, 8'd0, 8'd0}, 8, 1, -1, 0, 256);
        // R9/R10: start during the grace cycle and during the halt, with changed inputs
        run(4'b0001, {8'd0, 8'd0, 8'd0, 8'd2}, 8, 0, -1, 3, 2);
        run(4'b0101, {8'd0, 8'd1, 8'd0, 8'd3}, 6, 2, -1, 20, 4);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule